// File: doc/BRIEF.md
# Post-Increment Load/Store Execution Stage

This block is the memory stage of a 64-bit RISC core for load and store operations whose base register is updated after the access. It takes one operation that has already been decoded. The operation carries the target, base and displacement fields of the instruction word, a few control bits, and the register operands: base, index and store data. It places a single access on a valid/ready memory port. The address of that access is the base register value as it stands, not base plus offset. Once the memory response is back, the block retires the operation in one cycle. A retiring load writes two registers: the loaded value and the advanced base. A retiring store writes only the advanced base.

The advance is either the sign-extended 16-bit displacement, the doubleword form's word-scaled 14-bit displacement, or the index register. The memory bus is eight bytes wide. The block picks the byte lanes from the low three address bits and drives byte enables. An access that would run past the end of its 8-byte line is refused with an error flag. A load whose base register is r0, or is the same register as its target, is also refused with an error flag. A refused operation reaches memory not at all and writes no register.

The controller has four states:
- IDLE: waiting for an operation.
- ISSUE: request held on the memory port.
- AWAIT: request taken, waiting for the response.
- RETIRE: one cycle in which the writebacks or the error flags are driven.

The transitions are:
- accept-good: IDLE to ISSUE.
- accept-bad: IDLE to RETIRE, for an invalid form or a line crossing.
- grant: ISSUE to AWAIT, when the memory takes the request.
- respond: AWAIT to RETIRE, when the response arrives.
- finish: RETIRE to IDLE.

Top module: `pilsu_unit`

## Requirements
- R1: The memory address is the base operand with its low three bits cleared. Those three bits (the offset) select the first byte lane. Lane i carries address line+i, little-endian.
- R2: In the instruction word, bits 25:21 are the target register, bits 20:16 are the base register, and bits 15:0 are the displacement. In immediate form the base writeback value is base + sign-extended displacement, written to the base register number.
- R3: In doubleword form (op_dsform=1, op_indexed=0), the displacement used is {bits 15:2, 2'b00}, sign-extended.
- R4: In indexed form (op_indexed=1), the base writeback value is base + index operand.
- R5: op_size encodes the access size as 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. With op_signed=0, a load returns the accessed bytes zero-extended to 64 bits. A doubleword load returns all 64 bits.
- R6: With op_signed=1, halfword and word loads are sign-extended to 64 bits. For byte and doubleword loads, op_signed has no effect.
- R7: A store drives the low 1, 2, 4 or 8 bytes of the store data onto the enabled lanes, starting at the offset lane. Only those lanes are enabled. It retires with the base writeback and no data writeback.
- R8: A load whose base register is 0, or equals its target register, retires with wb_err_invalid. It makes no memory request and asserts neither writeback enable. Stores are exempt from this check.
- R9: An access where offset + size in bytes exceeds 8 retires with wb_err_misalign. It makes no memory request and asserts neither writeback enable.
- R10: Writebacks are driven only in the retire cycle. The retire cycle is the cycle directly after the response cycle, and both writebacks of a load appear in it together.
- R11: op_busy is high from the cycle after acceptance through the retire cycle. op_valid is ignored while op_busy is high. At most one request is outstanding. A request that is not yet granted keeps its address, enables and data stable. After reset, op_busy, mreq_valid and wb_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered; accepted when op_busy is low |
| op_busy | output | 1 | Operation in progress |
| op_word | input | 26 | Instruction word bits 25:0 (target, base, displacement) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_signed | input | 1 | Sign-extending load |
| op_indexed | input | 1 | Advance by index operand |
| op_dsform | input | 1 | Word-scaled displacement (doubleword immediate form) |
| op_size | input | 2 | Access size code |
| op_base | input | DATA_W | Base register value |
| op_index | input | DATA_W | Index register value |
| op_sdata | input | DATA_W | Store data register value |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request taken |
| mreq_we | output | 1 | Request is a write |
| mreq_addr | output | DATA_W | Line-aligned address |
| mreq_be | output | DATA_W/8 | Byte enables |
| mreq_wdata | output | DATA_W | Write data on lanes |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_rdata | input | DATA_W | Read data of the line |
| wb_valid | output | 1 | Retire cycle |
| wb_err_invalid | output | 1 | Invalid load form refused |
| wb_err_misalign | output | 1 | Line-crossing access refused |
| wb_data_en | output | 1 | Load data writeback enable |
| wb_data_idx | output | 5 | Load data destination register |
| wb_data | output | DATA_W | Load data |
| wb_base_en | output | 1 | Base writeback enable |
| wb_base_idx | output | 5 | Base destination register |
| wb_base | output | DATA_W | Advanced base value |

## Verification
The bench builds the block with DATA_W=64, the only width whose lane count matches the four size codes. With eight lanes, every offset from 0 to 7 can be combined with every size. That puts both edges of the line-crossing rule within reach: a halfword at offset 6 is legal, and the same halfword at offset 7 is refused. A behavioural byte-array memory with varying grant and response delays lets stores be read back through later loads. It also lets the retire-cycle timing be checked against the response cycle seen by the bench.

// File: rtl/pilsu_pkg.sv
package pilsu_pkg;
    localparam int REG_AW  = 5;
    localparam int DISP_W  = 16;
    localparam int RT_LSB  = 21;
    localparam int RA_LSB  = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_AWAIT,
        S_RETIRE
    } lsu_state_e;

    typedef struct packed {
        logic              store;
        logic              sgn;
        acc_size_e         size;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] ra;
    } op_ctl_t;
endpackage

// File: rtl/pilsu_incr.sv
module pilsu_incr
    import pilsu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    input  logic              dsform,
    output logic [DATA_W-1:0] next_base
);
    logic [DISP_W-1:0] disp_eff;
    logic [DATA_W-1:0] disp_ext;

    always_comb begin
        disp_eff  = dsform ? {disp[DISP_W-1:2], 2'b00} : disp;
        disp_ext  = {{(DATA_W-DISP_W){disp_eff[DISP_W-1]}}, disp_eff};
        next_base = base + (indexed ? index : disp_ext);
    end
endmodule

// File: rtl/pilsu_lane.sv
module pilsu_lane
    import pilsu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  acc_size_e                   size,
    input  logic [DATA_W-1:0]           sdata,
    output logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           wdata,
    output logic                        misalign
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W:0] nbytes;
    logic [OFF_W:0] end_pos;

    always_comb begin
        nbytes   = (OFF_W+1)'(1) << size;
        end_pos  = {1'b0, off} + nbytes;
        misalign = end_pos > (OFF_W+1)'(LANES);
        wdata    = sdata << {off, 3'b000};
    end

    for (genvar i = 0; i < LANES; i++) begin : g_be
        assign be[i] = ({1'b0, off} <= (OFF_W+1)'(i)) && ((OFF_W+1)'(i) < end_pos);
    end
endmodule

// File: rtl/pilsu_extract.sv
module pilsu_extract
    import pilsu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]           rdata,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  acc_size_e                   size,
    input  logic                        sgn,
    output logic [DATA_W-1:0]           value
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = rdata >> {off, 3'b000};
        unique case (size)
            SZ_BYTE: value = {{(DATA_W-8){1'b0}}, shifted[7:0]};
            SZ_HALF: value = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
            SZ_WORD: value = {{(DATA_W-32){sgn & shifted[31]}}, shifted[31:0]};
            default: value = shifted;
        endcase
    end
endmodule

// File: rtl/pilsu_unit.sv
module pilsu_unit
    import pilsu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    output logic                op_busy,
    input  logic [25:0]         op_word,
    input  logic                op_store,
    input  logic                op_signed,
    input  logic                op_indexed,
    input  logic                op_dsform,
    input  logic [1:0]          op_size,
    input  logic [DATA_W-1:0]   op_base,
    input  logic [DATA_W-1:0]   op_index,
    input  logic [DATA_W-1:0]   op_sdata,
    output logic                mreq_valid,
    input  logic                mreq_ready,
    output logic                mreq_we,
    output logic [DATA_W-1:0]   mreq_addr,
    output logic [DATA_W/8-1:0] mreq_be,
    output logic [DATA_W-1:0]   mreq_wdata,
    input  logic                mrsp_valid,
    input  logic [DATA_W-1:0]   mrsp_rdata,
    output logic                wb_valid,
    output logic                wb_err_invalid,
    output logic                wb_err_misalign,
    output logic                wb_data_en,
    output logic [4:0]          wb_data_idx,
    output logic [DATA_W-1:0]   wb_data,
    output logic                wb_base_en,
    output logic [4:0]          wb_base_idx,
    output logic [DATA_W-1:0]   wb_base
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    lsu_state_e state_q, state_d;
    op_ctl_t    ctl_d, ctl_q;

    logic [DATA_W-1:0] base_q, nbase_q, wdata_q, ld_q;
    logic [LANES-1:0]  be_q;
    logic              inv_q, mis_q;

    logic [DATA_W-1:0] nbase_c, wdata_c, ld_c;
    logic [LANES-1:0]  be_c;
    logic              mis_c, bad_form, accept;

    always_comb begin
        ctl_d.store = op_store;
        ctl_d.sgn   = op_signed;
        ctl_d.size  = acc_size_e'(op_size);
        ctl_d.rt    = op_word[RT_LSB +: REG_AW];
        ctl_d.ra    = op_word[RA_LSB +: REG_AW];
        bad_form    = !op_store && ((ctl_d.ra == '0) || (ctl_d.ra == ctl_d.rt));
        accept      = op_valid && (state_q == S_IDLE);
    end

    pilsu_incr #(.DATA_W(DATA_W)) u_incr (
        .base      (op_base),
        .index     (op_index),
        .disp      (op_word[DISP_W-1:0]),
        .indexed   (op_indexed),
        .dsform    (op_dsform),
        .next_base (nbase_c)
    );

    pilsu_lane #(.DATA_W(DATA_W)) u_lane (
        .off      (op_base[OFF_W-1:0]),
        .size     (ctl_d.size),
        .sdata    (op_sdata),
        .be       (be_c),
        .wdata    (wdata_c),
        .misalign (mis_c)
    );

    pilsu_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata (mrsp_rdata),
        .off   (base_q[OFF_W-1:0]),
        .size  (ctl_q.size),
        .sgn   (ctl_q.sgn),
        .value (ld_c)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (op_valid)   state_d = (bad_form || mis_c) ? S_RETIRE : S_ISSUE;
            S_ISSUE:  if (mreq_ready) state_d = S_AWAIT;
            S_AWAIT:  if (mrsp_valid) state_d = S_RETIRE;
            S_RETIRE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operation capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            base_q  <= '0;
            nbase_q <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            inv_q   <= 1'b0;
            mis_q   <= 1'b0;
            ld_q    <= '0;
        end else begin
            if (accept) begin
                ctl_q   <= ctl_d;
                base_q  <= op_base;
                nbase_q <= nbase_c;
                wdata_q <= wdata_c;
                be_q    <= be_c;
                inv_q   <= bad_form;
                mis_q   <= mis_c;
            end
            if (state_q == S_AWAIT && mrsp_valid) ld_q <= ld_c;
        end
    end

    // outputs
    always_comb begin
        op_busy         = (state_q != S_IDLE);
        mreq_valid      = (state_q == S_ISSUE);
        mreq_we         = ctl_q.store;
        mreq_addr       = {base_q[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
        mreq_be         = be_q;
        mreq_wdata      = wdata_q;
        wb_valid        = (state_q == S_RETIRE);
        wb_err_invalid  = wb_valid && inv_q;
        wb_err_misalign = wb_valid && mis_q;
        wb_base_en      = wb_valid && !inv_q && !mis_q;
        wb_data_en      = wb_base_en && !ctl_q.store;
        wb_data_idx     = ctl_q.rt;
        wb_data         = ld_q;
        wb_base_idx     = ctl_q.ra;
        wb_base         = nbase_q;
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_be) && $stable(mreq_wdata)); // R11
    AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> $countones(mreq_be) == (1 << ctl_q.size)); // R1
    AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && (wb_err_invalid || wb_err_misalign) |-> !wb_data_en && !wb_base_en); // R8
    AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && mreq_we |-> !wb_data_en); // R7
    AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_base_en |-> $past(mrsp_valid)); // R10
    AST_NO_REQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> !inv_q && !mis_q); // R9
endmodule

// File: tb/pilsu_unit_test.sv
module pilsu_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        op_valid = 0, op_busy;
    logic [25:0] op_word = '0;
    logic        op_store = 0, op_signed = 0, op_indexed = 0, op_dsform = 0;
    logic [1:0]  op_size = '0;
    logic [63:0] op_base = '0, op_index = '0, op_sdata = '0;
    logic        mreq_valid, mreq_ready, mreq_we;
    logic [63:0] mreq_addr, mreq_wdata;
    logic [7:0]  mreq_be;
    logic        mrsp_valid;
    logic [63:0] mrsp_rdata;
    logic        wb_valid, wb_err_invalid, wb_err_misalign, wb_data_en, wb_base_en;
    logic [4:0]  wb_data_idx, wb_base_idx;
    logic [63:0] wb_data, wb_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    pilsu_unit #(.DATA_W(64)) uut (.*);

    int checks = 0, fails = 0, req_count = 0, wait_ctr = 0;
    bit finished = 0;
    logic [7:0]  bmem [0:255];
    logic [63:0] cap_addr, cap_wdata;
    logic [7:0]  cap_be;
    logic        cap_we;
    time         rsp_time = 0;

    task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // behavioural memory: variable grant and response delay
    initial begin
        mreq_ready = 0; mrsp_valid = 0; mrsp_rdata = '0;
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 11);
        forever begin
            @(negedge clk);
            if (mreq_ready) begin
                mreq_ready = 0;
                req_count++;
                wait_ctr = 0;
                repeat (req_count % 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    if (cap_we && cap_be[i]) bmem[8'(cap_addr + 64'(i))] = cap_wdata[8*i +: 8];
                    mrsp_rdata[8*i +: 8] = bmem[8'(cap_addr + 64'(i))];
                end
                mrsp_valid = 1;
                rsp_time = $time;
                @(negedge clk);
                mrsp_valid = 0;
            end else if (mreq_valid) begin
                if (wait_ctr < req_count % 3) wait_ctr++;
                else begin
                    mreq_ready = 1;
                    cap_addr = mreq_addr; cap_be = mreq_be;
                    cap_wdata = mreq_wdata; cap_we = mreq_we;
                end
            end
        end
    end

    task automatic run_op(input string nm, input bit st, input bit sg, input bit ix, input bit ds,
                          input int sz, input int rt, input int ra, input logic [15:0] disp,
                          input logic [63:0] base, input logic [63:0] idx, input logic [63:0] sd,
                          input bit poke);
        int nb = 1 << sz;
        int off = int'(base[2:0]);
        bit inv = !st && (ra == 0 || ra == rt);
        bit mis = (off + nb) > 8;
        bit err = inv || mis;
        logic [15:0] de = ds ? {disp[15:2], 2'b00} : disp;
        logic [63:0] nbase = base + (ix ? idx : {{48{de[15]}}, de});
        logic [63:0] ld = '0, ebe = '0, ewd = '0, mask = '0;
        int n0 = req_count;
        bit got = 0;
        for (int i = 0; i < nb; i++) ld[8*i +: 8] = bmem[8'(base + 64'(i))];
        if (sg && (sz == 1 || sz == 2) && ld[8*nb-1]) for (int i = 8*nb; i < 64; i++) ld[i] = 1'b1;
        for (int i = 0; i < 8; i++) if (i >= off && i < off + nb) begin
            ebe[i] = 1'b1;
            mask[8*i +: 8] = 8'hFF;
            ewd[8*i +: 8] = sd[8*(i-off) +: 8];
        end
        @(negedge clk);
        op_valid = 1; op_word = {5'(rt), 5'(ra), disp};
        op_store = st; op_signed = sg; op_indexed = ix; op_dsform = ds; op_size = 2'(sz);
        op_base = base; op_index = idx; op_sdata = sd;
        @(negedge clk);
        if (poke) begin
            op_word = {5'd9, 5'd10, 16'h0040}; op_base = base + 64'h100; op_store = 1;
        end else op_valid = 0;
        for (int k = 0; k < 60 && !got; k++) begin
            if (wb_valid) got = 1;
            else begin
                if (poke) chk("R11", {nm, " busy while in flight"}, 64'(op_busy), 64'd1);
                @(negedge clk);
            end
        end
        op_valid = 0;
        chk("R10", {nm, " retired"}, 64'(got), 64'd1);
        chk("R8", {nm, " invalid flag"}, 64'(wb_err_invalid), 64'(inv));
        chk("R9", {nm, " misalign flag"}, 64'(wb_err_misalign), 64'(mis && !inv) | 64'(mis && inv));
        chk("R8", {nm, " base wb enable"}, 64'(wb_base_en), 64'(!err));
        chk("R7", {nm, " data wb enable"}, 64'(wb_data_en), 64'(!err && !st));
        if (err) begin
            chk("R9", {nm, " no request"}, 64'(req_count), 64'(n0));
        end else begin
            chk("R11", {nm, " one request"}, 64'(req_count), 64'(n0 + 1));
            chk("R10", {nm, " retire after response"}, 64'($time - rsp_time), 64'(CLK_PERIOD));
            chk("R1", {nm, " address"}, cap_addr, {base[63:3], 3'b000});
            chk("R1", {nm, " enables"}, 64'(cap_be), ebe);
            chk("R7", {nm, " write flag"}, 64'(cap_we), 64'(st));
            chk("R2", {nm, " base index"}, 64'(wb_base_idx), 64'(ra));
            chk(ix ? "R4" : (ds ? "R3" : "R2"), {nm, " new base"}, wb_base, nbase);
            if (st) chk("R7", {nm, " lane data"}, cap_wdata & mask, ewd);
            else begin
                chk("R2", {nm, " data index"}, 64'(wb_data_idx), 64'(rt));
                chk(sg ? "R6" : "R5", {nm, " load value"}, wb_data, ld);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset busy", 64'(op_busy), 0);
        chk("R11", "reset request", 64'(mreq_valid), 0);
        chk("R11", "reset retire", 64'(wb_valid), 0);
        rst_n = 1;
        // loads: immediate, indexed, scaled displacement
        run_op("lbz_imm",  0,0,0,0, 0, 3, 4, 16'h0010, 64'h1000_0013, 0, 0, 0);
        run_op("lhz_neg",  0,0,0,0, 1, 5, 6, 16'hFFF8, 64'h2000_0022, 0, 0, 0);
        run_op("lha",      0,1,0,0, 1, 7, 8, 16'h0002, 64'h0000_0034, 0, 0, 0);
        run_op("lha_hi",   0,1,0,0, 1, 7, 8, 16'h0002, 64'h0000_0006, 0, 0, 0);
        run_op("lwa_ix",   0,1,1,0, 2, 9, 2, 16'h0000, 64'h0000_0054, 64'h100, 0, 0);
        run_op("lwz_ix",   0,0,1,0, 2, 9, 2, 16'h0000, 64'h0000_0054, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0);
        run_op("ld_ds",    0,0,0,1, 3, 11, 12, 16'hFFF7, 64'h0000_0040, 0, 0, 0);
        run_op("ld_ds_pos",0,0,0,1, 3, 11, 12, 16'h0123, 64'h0000_0048, 0, 0, 0);
        run_op("lbz_sgn",  0,1,0,0, 0, 1, 13, 16'h0001, 64'h0000_0007, 0, 0, 0);
        run_op("ld_sgn",   0,1,0,0, 3, 1, 13, 16'h0008, 64'h0000_0010, 0, 0, 0);
        // stores, read back by loads
        run_op("stb",  1,0,0,0, 0, 14, 15, 16'h0001, 64'h0000_0085, 0, 64'h1122_3344_5566_77F0, 0);
        run_op("lb_back", 0,0,0,0, 0, 3, 4, 16'h0000, 64'h0000_0085, 0, 0, 0);
        run_op("sth",  1,0,1,0, 1, 14, 15, 16'h0000, 64'h0000_0096, 64'h2, 64'hAAAA_BBBB_CCCC_9ABC, 0);
        run_op("lha_back", 0,1,0,0, 1, 3, 4, 16'h0000, 64'h0000_0096, 0, 0, 0);
        run_op("stw",  1,0,0,0, 2, 14, 14, 16'h0004, 64'h0000_00A0, 0, 64'h0123_4567_89AB_CDEF, 0);
        run_op("lwa_back", 0,1,0,0, 2, 3, 4, 16'h0000, 64'h0000_00A0, 0, 0, 0);
        run_op("std_r0", 1,0,0,1, 3, 14, 0, 16'h0008, 64'h0000_00B0, 0, 64'hFEDC_BA98_7654_3210, 0);
        run_op("ld_back", 0,0,0,0, 3, 3, 4, 16'h0000, 64'h0000_00B0, 0, 0, 0);
        // refused forms
        run_op("ld_ra0",   0,0,0,0, 2, 3, 0, 16'h0004, 64'h0000_0020, 0, 0, 0);
        run_op("ld_ra_rt", 0,0,0,0, 0, 6, 6, 16'h0004, 64'h0000_0020, 0, 0, 0);
        run_op("lw_cross", 0,0,0,0, 2, 3, 4, 16'h0004, 64'h0000_0026, 0, 0, 0);
        run_op("ld_cross", 0,0,0,0, 3, 3, 4, 16'h0004, 64'h0000_0021, 0, 0, 0);
        run_op("lh_off7",  0,0,0,0, 1, 3, 4, 16'h0004, 64'h0000_0027, 0, 0, 0);
        run_op("lh_off6",  0,0,0,0, 1, 3, 4, 16'h0004, 64'h0000_0026, 0, 0, 0);
        run_op("sw_cross", 1,0,0,0, 2, 3, 4, 16'h0004, 64'h0000_0035, 0, 64'h55, 0);
        // offer during busy
        run_op("poke", 0,0,0,0, 2, 17, 18, 16'h0020, 64'h0000_0060, 0, 0, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule